// File: doc/BRIEF.md
# Write Qualifier with Power Hold-off and Strobe Glitch Rejection

This block sits in front of the write controller of a byte-wide parallel nonvolatile memory. It decides when a host write may begin. The host drives three active-low control strobes: chip-enable, output-enable and write-enable. An external comparator supplies one digital bit that reports whether the supply rail is above its threshold of about 3.8 V. The block samples all four inputs on its own clock. It produces a single-cycle write-start pulse only when all of the following hold:

- the supply has been good for the whole power-on hold-off;
- the strobes are in the one combination that means "write";
- both chip-enable and write-enable have been asserted long enough to pass a minimum-width filter.

The hold-off stands for a delay of about 5 ms and is set as a number of clock cycles. The minimum width stands for about 15 ns and is also set in clock cycles. Every input first passes through a reset-initialised synchroniser. A loss of supply at any moment clears the hold-off, and the whole delay must then elapse again. The controller downstream sees one pulse per qualified write, at the moment the qualified strobe combination becomes true.

Top module: `wr_guard`

## Requirements
- R1: While the synchronised supply-good bit is 0, no write-start pulse is produced, whatever the strobes do.
- R2: With the strobes already in the write combination, the first write-start appears on the (SYNC_STAGES + HOLDOFF_CYC)-th rising clock edge after supply_ok goes to 1, and not one edge earlier.
- R3: While oe_n is 0 (output enabled), no write-start is produced.
- R4: While ce_n is 1 (chip deselected), no write-start is produced.
- R5: While we_n is 1 (write-enable deasserted), no write-start is produced.
- R6: An asserted-low pulse on we_n or on ce_n that is sampled for fewer than MIN_PW_CYC clock edges starts no write. A pulse of exactly MIN_PW_CYC samples is accepted.
- R7: wr_start is 0 in reset and is never high for two consecutive cycles. Holding the write combination for a long time gives exactly one pulse.
- R8: A drop of supply_ok lasting a single sampled cycle during the hold-off restarts it. The next write-start then needs the full SYNC_STAGES + HOLDOFF_CYC edges after the recovery.
- R9: After power-up, with ce_n low and oe_n high, driving we_n low produces wr_start on the (SYNC_STAGES + MIN_PW_CYC)-th rising edge that samples it low. A write may also be started by chip-enable while write-enable is already held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | 1 when the external comparator reports the supply above threshold |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| wr_start | output | 1 | Single-cycle qualified write-start pulse to the write controller |

## Verification
The assertions check several properties on every cycle:

- any write-start coincides with an expired hold-off, a high synchronised output-enable and both strobe filters passing;
- the pulse never lasts beyond one cycle;
- a supply loss clears readiness by the next cycle;
- a filter can never pass on the cycle its input first rises.

Only the bench scenarios can show the exact cycle counts. These are the hold-off length and its restart after a one-cycle supply dip, the acceptance of a pulse of exactly the minimum width against the rejection of one cycle less, and the end-to-end latency through the synchronisers.

// File: rtl/wg_pkg.sv
// Package: shared defaults and strobe indices for the write qualifier.
// Assumes a sampling clock of roughly 100 MHz when reading the defaults.
package wg_pkg;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned HOLDOFF_DEF     = 500_000; // about 5 ms of clock cycles
    localparam int unsigned MIN_PW_DEF      = 2;       // about 15 ns of clock cycles
    localparam int unsigned N_FILT          = 2;
    localparam int unsigned FILT_CE         = 0;
    localparam int unsigned FILT_WE         = 1;
endpackage

// File: rtl/wg_sync.sv
// Module: multi-stage synchroniser for a small bus of slow control inputs.
// Assumes each bit is independent; STAGES >= 1; reset loads RST_VAL everywhere.
module wg_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the sampled inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wg_holdoff.sv
// Module: power-on hold-off. Counts consecutive good-supply cycles and
// reports ready once HOLDOFF_CYC of them have been seen. Any bad cycle
// clears the count. Assumes sup_ok is already synchronised; HOLDOFF_CYC >= 1.
module wg_holdoff #(
    parameter int unsigned HOLDOFF_CYC = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    output logic ready
);
    localparam int unsigned CW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYC);

    logic [CW-1:0] cnt;

    // Count good-supply cycles up to the limit; restart on any bad cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!sup_ok)        cnt <= '0;
        else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == LIMIT);

    AST_READY_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> !ready); // R1
    AST_HOLDOFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_ok) |-> !ready); // R8
endmodule

// File: rtl/wg_pulse_filter.sv
// Module: minimum-width filter. The output passes once the input has been
// high for MIN_PW_CYC consecutive samples, and it drops as soon as the
// input has been seen low. Assumes a synchronised input; MIN_PW_CYC >= 1.
module wg_pulse_filter #(
    parameter int unsigned MIN_PW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_act,
    output logic pass
);
    localparam int unsigned CW = $clog2(MIN_PW_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_PW_CYC);

    logic [CW-1:0] run;

    // Measure the current run of high samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              run <= '0;
        else if (!in_act)        run <= '0;
        else if (run != LIMIT)   run <= run + 1'b1;
    end

    assign pass = (run == LIMIT);

    AST_PASS_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> $past(in_act)); // R6
    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_act) |-> !pass); // R6
endmodule

// File: rtl/wr_guard.sv
// Module: write qualifier top. Synchronises the supply-good bit and the
// three active-low strobes, applies the power-on hold-off, filters
// chip-enable and write-enable for minimum width, requires output-enable
// high, and emits one pulse when the qualified combination turns true.
// Assumes asynchronous inputs; the downstream controller takes a one-cycle start.
module wr_guard
    import wg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned HOLDOFF_CYC = HOLDOFF_DEF,
    parameter int unsigned MIN_PW_CYC  = MIN_PW_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start
);
    logic              sup_s, oe_n_s, ce_n_s, we_n_s;
    logic [N_FILT-1:0] strobe_act;
    logic [N_FILT-1:0] strobe_pass;
    logic              ready;
    logic              armed, armed_q;

    wg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({supply_ok, oe_n, ce_n, we_n}),
        .q({sup_s, oe_n_s, ce_n_s, we_n_s})
    );

    wg_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_s), .ready(ready)
    );

    assign strobe_act[FILT_CE] = ~ce_n_s;
    assign strobe_act[FILT_WE] = ~we_n_s;

    for (genvar g = 0; g < int'(N_FILT); g++) begin : g_filt
        wg_pulse_filter #(.MIN_PW_CYC(MIN_PW_CYC)) u_filt (
            .clk(clk), .rst_n(rst_n),
            .in_act(strobe_act[g]), .pass(strobe_pass[g])
        );
    end

    assign armed = ready & oe_n_s & (&strobe_pass);

    // Remember the previous qualified state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed;
    end

    assign wr_start = armed & ~armed_q;

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start); // R7
    AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> ready); // R1
    AST_START_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> oe_n_s); // R3
    AST_START_CE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> strobe_pass[FILT_CE]); // R4
    AST_START_WE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> strobe_pass[FILT_WE]); // R5
endmodule

// File: tb/sim_wr_guard.sv
// Directed bench for wr_guard: one task per scenario, each checking itself.
module sim_wr_guard;
    localparam int S = 2;
    localparam int H = 40;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic ce_n = 1'b0;
    logic oe_n = 1'b1;
    logic we_n = 1'b0;
    logic wr_start;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wr_guard #(.SYNC_STAGES(S), .HOLDOFF_CYC(H), .MIN_PW_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wr_start(wr_start)
    );

    // Count write-start cycles away from the active edge.
    always @(negedge clk) if (rst_n && wr_start) pulses++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int snap();
        return pulses;
    endfunction

    // Read the pulse counter safely after a rising edge.
    task automatic read_cnt(output int v);
        @(posedge clk); #1;
        v = pulses;
    endtask

    task automatic we_pulse(input int n);
        @(negedge clk) we_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk) we_n = 1'b1;
    endtask

    task automatic ce_pulse(input int n);
        @(negedge clk) ce_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk) ce_n = 1'b1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R7 reset output low", int'(wr_start), 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_power_up;
        int c0, c1;
        c0 = snap();
        repeat (20) @(negedge clk);
        read_cnt(c1);
        chk("R1 no start while supply low", c1 - c0, 0);
        @(negedge clk) supply_ok = 1'b1;
        repeat (S + H - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 blocked one edge before hold-off end", int'(wr_start), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 start at hold-off end", int'(wr_start), 1);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", int'(wr_start), 0);
        ce_n = 1'b1;
        we_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_latency;
        int c0, c1;
        @(negedge clk) ce_n = 1'b0;
        repeat (8) @(negedge clk);
        c0 = snap();
        we_n = 1'b0;
        repeat (S + P - 1) @(posedge clk);
        @(negedge clk);
        chk("R9 no start one edge early", int'(wr_start), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 start at expected edge", int'(wr_start), 1);
        repeat (15) @(negedge clk);
        read_cnt(c1);
        chk("R7 long hold gives one pulse", c1 - c0, 1);
        @(negedge clk) we_n = 1'b1;
        ce_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_filter;
        int c0, c1;
        @(negedge clk) ce_n = 1'b0;
        repeat (8) @(negedge clk);
        c0 = snap();
        we_pulse(P - 1);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R6 short write-enable rejected", c1 - c0, 0);
        c0 = c1;
        we_pulse(P);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R6 exact-width write-enable accepted", c1 - c0, 1);
        @(negedge clk) ce_n = 1'b1;
        we_n = 1'b0;
        repeat (8) @(negedge clk);
        c0 = snap();
        ce_pulse(P - 1);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R6 short chip-enable rejected", c1 - c0, 0);
        c0 = c1;
        ce_pulse(P);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R9 R6 chip-enable started write accepted", c1 - c0, 1);
        @(negedge clk) we_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_inhibits;
        int c0, c1;
        @(negedge clk) oe_n = 1'b0;
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        c0 = snap();
        we_pulse(8);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R3 output-enable low blocks write", c1 - c0, 0);
        @(negedge clk) ce_n = 1'b1;
        repeat (5) @(negedge clk);
        oe_n = 1'b1;
        repeat (5) @(negedge clk);
        c0 = snap();
        we_pulse(8);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R4 chip-enable high blocks write", c1 - c0, 0);
        c0 = c1;
        ce_pulse(8);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R5 write-enable high blocks write", c1 - c0, 0);
    endtask

    task automatic t_supply;
        int c0, c1;
        @(negedge clk) supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        c0 = snap();
        ce_n = 1'b0;
        we_pulse(8);
        repeat (10) @(negedge clk);
        read_cnt(c1);
        chk("R1 supply loss blocks write", c1 - c0, 0);
        @(negedge clk) we_n = 1'b0;
        repeat (8) @(negedge clk);
        supply_ok = 1'b1;
        repeat (H / 2) @(posedge clk);
        @(negedge clk) supply_ok = 1'b0;
        @(posedge clk);
        @(negedge clk) supply_ok = 1'b1;
        repeat (S + H - 1) @(posedge clk);
        @(negedge clk);
        chk("R8 restarted hold-off still blocking", int'(wr_start), 0);
        read_cnt(c1);
        chk("R8 no start during restarted hold-off", c1 - c0, 0);
        @(negedge clk);
        chk("R8 start after full restarted hold-off", int'(wr_start), 1);
        ce_n = 1'b1;
        we_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_latency();
        t_filter();
        t_inhibits();
        t_supply();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule